// File: doc/BRIEF.md
# Sleep-State Supply Plane Controller

This block turns two active-low sleep request lines from the platform power manager into switch enables for three supply planes: an auxiliary 3.3 V plane, an auxiliary 5 V plane and a memory plane. Each plane has two enables. One closes the switch fed from the main supply. The other turns on the path fed from the standby supply. Two keep inputs choose whether each auxiliary plane stays powered during the deeper sleep state. The suspend keep input also governs the 5 V plane in suspend-to-RAM.

The request lines pass through a two-flop synchronizer and then a stability filter. A new request code takes effect only after it has held steady for a programmable number of clock cycles. Illegal codes are ignored, and so are direct moves between the two sleep states. The keep inputs are sampled only while the block is awake or held off. Their value is frozen the moment a sleep state is entered. A shutdown input or a low power-good qualifier forces every enable low and returns the state to active.

Top module: `sleep_plane_ctrl`

## Requirements
- R1: With the request lines decoded as {s3_n, s5_n}, code 2'b11 selects active, 2'b01 selects suspend-to-RAM and 2'b00 selects soft-off, each reached only from a state that permits it.
- R2: Code 2'b10 is illegal, and while it is present the current state is kept.
- R3: There is no direct move between suspend-to-RAM and soft-off. From either sleep state, a request for the other sleep state leaves the state unchanged.
- R4: A request code changes the state only after it has been stable at the synchronizer output for FILT_CYC consecutive cycles. A pulse shorter than that has no effect.
- R5: The keep inputs are captured on the cycle a sleep state is entered. Changes to them during sleep do not alter the outputs.
- R6: The 3.3 V plane uses the main path in active and the standby path in suspend. In soft-off it uses the standby path only if aux3_keep was 1 at entry.
- R7: The 5 V plane uses the main path in active. In either sleep state it uses the standby path only if aux5_keep was 1 at entry.
- R8: The memory plane uses the main path in active and the standby path in suspend. Both of its enables are low in soft-off, whatever the keep inputs are.
- R9: For each plane, the main-path and standby-path enables are never high together.
- R10: While shutdown is high or power-good is low, all six enables are low from the next cycle on, and the state returns to active. After release, the block behaves as it does after reset.
- R11: While reset is asserted, all enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown_i | input | 1 | Forces all planes off while high |
| pwr_good_i | input | 1 | Power-good qualifier; planes stay off while low |
| slp3_n_i | input | 1 | Suspend-to-RAM request, active low, asynchronous |
| slp5_n_i | input | 1 | Soft-off request, active low, asynchronous |
| aux3_keep_i | input | 1 | Keep the 3.3 V plane on in soft-off |
| aux5_keep_i | input | 1 | Keep the 5 V plane on in sleep states |
| aux3_act_en_o | output | 1 | 3.3 V plane main-path switch |
| aux3_sby_en_o | output | 1 | 3.3 V plane standby-path enable |
| aux5_act_en_o | output | 1 | 5 V plane main-path switch |
| aux5_sby_en_o | output | 1 | 5 V plane standby-path enable |
| mem_act_en_o | output | 1 | Memory plane main-path enable |
| mem_sby_en_o | output | 1 | Memory plane standby-path enable |

## Verification
A corrupted state register appears at the ports within one cycle, because the six enables are decoded straight from it. A suspend/soft-off mix-up shows as the memory enables dropping or the 3.3 V standby enable ignoring its keep input. A stale keep latch becomes visible only at the next sleep entry, so the bench changes the keep inputs both before entry and while asleep. A filter counter that is too short or too long shows as an early state change after a sub-window glitch, or as no change at the moment a window has passed.

// File: rtl/sleep_plane_pkg.sv
package sleep_plane_pkg;
   typedef enum logic [1:0] {
      ST_ACTIVE = 2'd0,
      ST_SUSP   = 2'd1,
      ST_OFF    = 2'd2
   } pwr_state_e;

   localparam logic [1:0] CODE_ACTIVE = 2'b11;
   localparam logic [1:0] CODE_SUSP   = 2'b01;
   localparam logic [1:0] CODE_OFF    = 2'b00;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("req_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] pipe_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q[s] <= '1;
         else if (s == 0) pipe_q[s] <= d_i;
         else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/req_filter.sv
module req_filter #(
   parameter int FILT_CYC = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] code_i,
   output logic       vld_o,
   output logic [1:0] code_o
);
   localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
   localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);

   if (FILT_CYC < 2) begin : g_bad_filt
      $error("req_filter: FILT_CYC must be at least 2");
   end

   logic [1:0]    cand_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q <= 2'b11;
         cnt_q  <= '0;
      end else if (code_i != cand_q) begin
         cand_q <= code_i;
         cnt_q  <= '0;
      end else if (cnt_q != LIM) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign vld_o  = (cnt_q == LIM) && (code_i == cand_q);
   assign code_o = cand_q;
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
   import sleep_plane_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_i,
   input  logic       req_vld_i,
   input  logic [1:0] req_code_i,
   input  logic       keep3_i,
   input  logic       keep5_i,
   output pwr_state_e state_o,
   output logic       lat3_o,
   output logic       lat5_o,
   output logic       gate_o
);
   pwr_state_e state_q, state_d;
   logic       lat3_q, lat5_q, gate_q;

   always_comb begin
      state_d = state_q;
      if (hold_i) begin
         state_d = ST_ACTIVE;
      end else if (req_vld_i) begin
         unique case (state_q)
            ST_ACTIVE: begin
               if (req_code_i == CODE_SUSP)     state_d = ST_SUSP;
               else if (req_code_i == CODE_OFF) state_d = ST_OFF;
            end
            ST_SUSP, ST_OFF: begin
               if (req_code_i == CODE_ACTIVE) state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_ACTIVE;
         lat3_q  <= 1'b0;
         lat5_q  <= 1'b0;
         gate_q  <= 1'b1;
      end else begin
         state_q <= state_d;
         gate_q  <= hold_i;
         if (hold_i || state_q == ST_ACTIVE) begin
            lat3_q <= keep3_i;
            lat5_q <= keep5_i;
         end
      end
   end

   assign state_o = state_q;
   assign lat3_o  = lat3_q;
   assign lat5_o  = lat5_q;
   assign gate_o  = gate_q;
endmodule

// File: rtl/plane_dec.sv
module plane_dec
   import sleep_plane_pkg::*;
(
   input  pwr_state_e state_i,
   input  logic       lat3_i,
   input  logic       lat5_i,
   input  logic       gate_i,
   output logic [5:0] en_o
);
   logic a3a, a3s, a5a, a5s, ma, ms;

   always_comb begin
      a3a = 1'b0; a3s = 1'b0; a5a = 1'b0; a5s = 1'b0; ma = 1'b0; ms = 1'b0;
      unique case (state_i)
         ST_ACTIVE: begin a3a = 1'b1; a5a = 1'b1; ma = 1'b1; end
         ST_SUSP:   begin a3s = 1'b1; a5s = lat5_i; ms = 1'b1; end
         ST_OFF:    begin a3s = lat3_i; a5s = lat5_i; end
         default:   ;
      endcase
   end

   assign en_o = gate_i ? 6'b0 : {a3a, a3s, a5a, a5s, ma, ms};
endmodule

// File: rtl/sleep_plane_ctrl.sv
module sleep_plane_ctrl
   import sleep_plane_pkg::*;
#(
   parameter int FILT_CYC    = 200,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shutdown_i,
   input  logic pwr_good_i,
   input  logic slp3_n_i,
   input  logic slp5_n_i,
   input  logic aux3_keep_i,
   input  logic aux5_keep_i,
   output logic aux3_act_en_o,
   output logic aux3_sby_en_o,
   output logic aux5_act_en_o,
   output logic aux5_sby_en_o,
   output logic mem_act_en_o,
   output logic mem_sby_en_o
);
   logic [1:0] code_sync, req_code;
   logic       req_vld, hold, lat3, lat5, gate;
   pwr_state_e state_q;
   logic [5:0] en;

   assign hold = shutdown_i | ~pwr_good_i;

   req_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({slp3_n_i, slp5_n_i}), .q_o(code_sync));

   req_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .code_i(code_sync),
      .vld_o(req_vld), .code_o(req_code));

   sleep_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .hold_i(hold), .req_vld_i(req_vld),
      .req_code_i(req_code), .keep3_i(aux3_keep_i), .keep5_i(aux5_keep_i),
      .state_o(state_q), .lat3_o(lat3), .lat5_o(lat5), .gate_o(gate));

   plane_dec u_dec (
      .state_i(state_q), .lat3_i(lat3), .lat5_i(lat5), .gate_i(gate), .en_o(en));

   assign {aux3_act_en_o, aux3_sby_en_o, aux5_act_en_o,
           aux5_sby_en_o, mem_act_en_o, mem_sby_en_o} = en;
endmodule

// File: rtl/sleep_plane_ctrl_chk.sv
module sleep_plane_ctrl_chk
   import sleep_plane_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       hold,
   input logic       req_vld,
   input pwr_state_e state_q,
   input logic       lat3,
   input logic       lat5,
   input logic [5:0] en
);
   // R9: main and standby paths of one plane never both on
   p_path_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(en[5] && en[4]) && !(en[3] && en[2]) && !(en[1] && en[0]));

   // R3: no direct move between the two sleep states
   p_no_susp_to_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SUSP) |=> (state_q != ST_OFF));
   p_no_off_to_susp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OFF) |=> (state_q != ST_SUSP));

   // R4: state moves only on a qualified request (or the hold path)
   p_filter_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_vld && !hold) |=> $stable(state_q));

   // R5: keep latches frozen while asleep
   p_keep_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_ACTIVE && !hold) |=> ($stable(lat3) && $stable(lat5)));

   // R10: hold forces all enables low on the next cycle
   p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (en == 6'b0));

   // R8: memory plane dark in soft-off
   p_mem_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OFF) |-> (en[1:0] == 2'b00));
endmodule

bind sleep_plane_ctrl sleep_plane_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .hold(hold), .req_vld(req_vld),
   .state_q(state_q), .lat3(lat3), .lat5(lat5), .en(en));

// File: tb/sleep_plane_ctrl_bench.sv
`timescale 1ns/1ps
module sleep_plane_ctrl_bench;
   localparam int FILT = 200;
   localparam int M_ACT = 0, M_SUSP = 1, M_OFF = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic shutdown = 1'b0, pg = 1'b1, s3n = 1'b1, s5n = 1'b1, k3 = 1'b0, k5 = 1'b0;
   logic a3a, a3s, a5a, a5s, ma, ms;
   int checks = 0, errors = 0;
   int mst = M_ACT;
   logic ml3 = 1'b0, ml5 = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sleep_plane_ctrl #(.FILT_CYC(FILT)) u_sleep_plane_ctrl (
      .clk(clk), .rst_n(rst_n), .shutdown_i(shutdown), .pwr_good_i(pg),
      .slp3_n_i(s3n), .slp5_n_i(s5n), .aux3_keep_i(k3), .aux5_keep_i(k5),
      .aux3_act_en_o(a3a), .aux3_sby_en_o(a3s), .aux5_act_en_o(a5a),
      .aux5_sby_en_o(a5s), .mem_act_en_o(ma), .mem_sby_en_o(ms));

   function automatic logic [5:0] exp_en(int st, logic l3, logic l5);
      case (st)
         M_ACT:  return 6'b101010;
         M_SUSP: return {1'b0, 1'b1, 1'b0, l5, 1'b0, 1'b1};
         default: return {1'b0, l3, 1'b0, l5, 2'b00};
      endcase
   endfunction

   function automatic int next_st(int st, logic [1:0] code);
      if (st == M_ACT) begin
         if (code == 2'b01) return M_SUSP;
         if (code == 2'b00) return M_OFF;
         return M_ACT;
      end
      return (code == 2'b11) ? M_ACT : st;
   endfunction

   task automatic check(string req, logic [5:0] exp);
      logic [5:0] act = {a3a, a3s, a5a, a5s, ma, ms};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // apply a code and keeps, wait past the filter, update model, check
   task automatic step(logic [1:0] code, logic nk3, logic nk5, string req);
      int nst;
      {s3n, s5n} = code; k3 = nk3; k5 = nk5;
      wait_cyc(FILT + 10);
      nst = next_st(mst, code);
      if (mst == M_ACT && nst != M_ACT) begin ml3 = nk3; ml5 = nk5; end
      mst = nst;
      check(req, exp_en(mst, ml3, ml5));
   endtask

   initial begin
      wait_cyc(3);
      check("R11", 6'b0);
      rst_n = 1'b1;
      wait_cyc(3);
      check("R1", exp_en(M_ACT, 0, 0));

      // directed: suspend entry with keeps, then change keeps asleep
      step(2'b01, 1'b0, 1'b1, "R1/R7");
      k5 = 1'b0; k3 = 1'b1; wait_cyc(5);
      check("R5", exp_en(mst, ml3, ml5));
      step(2'b00, 1'b1, 1'b0, "R3");
      step(2'b10, 1'b1, 1'b0, "R2");
      step(2'b11, 1'b1, 1'b0, "R1");
      step(2'b00, 1'b1, 1'b0, "R6/R8");
      step(2'b01, 1'b0, 1'b0, "R3");
      step(2'b11, 1'b0, 1'b0, "R1");

      // R4: glitch shorter than the window
      {s3n, s5n} = 2'b01; wait_cyc(FILT / 2);
      {s3n, s5n} = 2'b11; wait_cyc(FILT + 10);
      check("R4", exp_en(mst, ml3, ml5));
      // R4: exactly at the window boundary the code lands
      {s3n, s5n} = 2'b00; k3 = 1'b1; k5 = 1'b1;
      wait_cyc(FILT - 2);
      check("R4", exp_en(M_ACT, 0, 0));
      wait_cyc(6);
      mst = M_OFF; ml3 = 1'b1; ml5 = 1'b1;
      check("R4", exp_en(mst, ml3, ml5));

      // R10: shutdown then release
      shutdown = 1'b1; wait_cyc(2);
      check("R10", 6'b0);
      mst = M_ACT;
      {s3n, s5n} = 2'b11; k3 = 1'b0; k5 = 1'b0;
      wait_cyc(FILT + 10);
      check("R10", 6'b0);
      shutdown = 1'b0; wait_cyc(3);
      check("R10", exp_en(M_ACT, 0, 0));
      pg = 1'b0; wait_cyc(2);
      check("R10", 6'b0);
      pg = 1'b1; wait_cyc(3);
      check("R10", exp_en(M_ACT, 0, 0));

      // constrained random
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 40; i++) begin
         logic [1:0] c = 2'($urandom_range(0, 3));
         step(c, 1'($urandom), 1'($urandom), "R1/R2/R3/R6/R7/R8");
         k3 = 1'($urandom); k5 = 1'($urandom);
         wait_cyc(3);
         if (mst != M_ACT) check("R5", exp_en(mst, ml3, ml5));
         else check("R9", exp_en(M_ACT, 0, 0));
      end
      done = 1'b1;
   end

   initial begin : watchdog
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog actual timeout expected completion");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule